// File: doc/BRIEF.md
# Latched PWM Fault Controller

This block sits between a PWM generator and the gate drivers and protects the power stage against overcurrent. An active-high comparator input is brought into the clock domain through a chain of synchronizer flops. Whenever the synchronized fault is present, or a stored fault is held, every high-side and low-side drive output is forced to a fixed safe level. In latched operation a fault is stored and stays in force after the comparator drops. A sticky interrupt flag records that a fault happened.

Releasing a stored fault takes a two-step sequence that is tied to PWM period boundaries. The PWM timebase marks each boundary with a one-cycle strobe. Software starts the sequence with a single request pulse. Phase one acts at once, in the current period. A build-time option selects its action: it either releases the stored fault directly, or suspends latched operation for the duration of the sequence. Phase two acts at the next period boundary. It clears the flag and, in the suspend variant, turns latched operation back on. A busy output stays high between the two phases.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset the drive outputs follow their inputs, and `fault_active`, `fault_flag` and `clr_busy` are all 0.
- R2: While no fault is active, each `pwm_hi_out` and `pwm_lo_out` bit equals the matching input bit, for every input pattern.
- R3: With `SYNC_STAGES`=2, a rise on `fault_in` that is set up before clock edge k first masks the outputs and raises `fault_active` after edge k+1. After edge k the outputs are not masked yet.
- R4: While `fault_active` is 1, every high-side output is `SAFE_HI` and every low-side output is `SAFE_LO`, whatever the drive inputs are. Both levels are 0 by default.
- R5: When `cfg_latch_en`=1, `fault_active` stays 1 after `fault_in` falls, until a clear sequence releases it.
- R6: `fault_flag` rises one clock after the synchronized fault is seen. It stays 1 until phase two of a clear sequence. A period strobe with no sequence running has no effect on the flag or on the fault state.
- R7: A `clr_req` in a clock with no sequence running starts phase one at that edge and sets `clr_busy`. With `CLR_SUSPEND`=0, the stored fault is released at that edge. With `CLR_SUSPEND`=1, latched operation is suspended and the stored fault is released one clock later. Phase one leaves `fault_flag` set.
- R8: Phase two happens at the first `period_strobe` sampled after the request clock. At that edge the flag clears and `clr_busy` falls. A strobe sampled in the same clock as the request does not count as the boundary.
- R9: A `clr_req` sampled while `clr_busy` is 1 is ignored. The sequence keeps waiting for its boundary and `fault_flag` is unchanged.
- R10: If the synchronized fault is still present when a phase acts, the set wins. With `CLR_SUSPEND`=0 the stored fault is not released. The flag stays set at phase two. With `CLR_SUSPEND`=1 the fault latches again on the clock after latched operation is re-enabled.
- R11: With `cfg_latch_en`=0, `fault_active` follows the synchronized fault cycle by cycle, while `fault_flag` remains sticky and clears only through the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | 1 | Overcurrent comparator, active high, asynchronous |
| period_strobe | input | 1 | One-cycle pulse at each PWM period boundary |
| cfg_latch_en | input | 1 | 1 selects latched fault operation |
| clr_req | input | 1 | Pulse requesting a clear sequence |
| pwm_hi_in | input | NUM_CH | High-side drive from the PWM generator |
| pwm_lo_in | input | NUM_CH | Low-side drive from the PWM generator |
| pwm_hi_out | output | NUM_CH | High-side drive to the gate drivers |
| pwm_lo_out | output | NUM_CH | Low-side drive to the gate drivers |
| fault_active | output | 1 | Outputs are currently forced to the safe level |
| fault_flag | output | 1 | Sticky fault interrupt flag |
| clr_busy | output | 1 | A clear sequence is between its two phases |

## Verification
A stored fault that is lost shows up the moment the comparator drops: the drive inputs reappear at the outputs when they should stay masked. The bench watches for this on the following clock. A flag or sequencer state that goes wrong shows on `fault_flag` and `clr_busy` at the edge where the strobe or the request is sampled. So the bench samples those outputs one edge after each request or strobe, and checks both the set-wins case and the re-latch case at their exact clocks. Masking is swept over every drive-input pattern, both masked and unmasked, for both phase-one variants side by side.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_WAIT = 1'b1
   } seq_state_e;

   // Control strobes from the clear sequencer to the fault store.
   typedef struct packed {
      logic release_now;   // drop the stored fault this edge
      logic suspend;       // latched operation suspended
      logic flag_clear;    // phase two: clear the sticky flag
      logic busy;          // between phase one and phase two
   } seq_ctl_t;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pfg_clear_seq.sv
module pfg_clear_seq
   import pfg_pkg::*;
#(
   parameter bit CLR_SUSPEND = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_req,
   input  logic     period_strobe,
   output seq_ctl_t ctl
);

   seq_state_e state_q;
   logic       start, finish, suspend_q;

   assign start  = (state_q == SEQ_IDLE) && clr_req;
   assign finish = (state_q == SEQ_WAIT) && period_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= SEQ_IDLE;
      else if (start)  state_q <= SEQ_WAIT;
      else if (finish) state_q <= SEQ_IDLE;
   end

   if (CLR_SUSPEND) begin : g_suspend
      // Phase one turns latched operation off, phase two turns it back on.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      suspend_q <= 1'b0;
         else if (start)  suspend_q <= 1'b1;
         else if (finish) suspend_q <= 1'b0;
      end
      assign ctl.release_now = 1'b0;
   end else begin : g_release
      // Phase one drops the stored fault directly.
      assign suspend_q       = 1'b0;
      assign ctl.release_now = start;
   end

   assign ctl.suspend    = suspend_q;
   assign ctl.flag_clear = finish;
   assign ctl.busy       = (state_q == SEQ_WAIT);

   a_r7_busy_start : assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.busy && clr_req) |=> ctl.busy);

   a_r9_busy_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.busy && !period_strobe) |=> ctl.busy);

   a_r8_busy_end : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.busy && period_strobe) |=> !ctl.busy);

endmodule

// File: rtl/pfg_fault_store.sv
module pfg_fault_store
   import pfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fault_s,
   input  logic     latch_en,
   input  seq_ctl_t ctl,
   output logic     active,
   output logic     flag
);

   logic latch_q, flag_q, latch_mode;

   assign latch_mode = latch_en && !ctl.suspend;

   // A set always beats a release in the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         latch_q <= latch_mode && (fault_s || (latch_q && !ctl.release_now));
         flag_q  <= fault_s || (flag_q && !ctl.flag_clear);
      end
   end

   assign active = latch_q || fault_s;
   assign flag   = flag_q;

   a_r6_flag_set : assert property (@(posedge clk) disable iff (!rst_n)
      fault_s |=> flag);

   a_r6_flag_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ctl.flag_clear) |=> flag);

   a_r8_flag_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.flag_clear && !fault_s) |=> !flag);

   a_r10_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (fault_s && latch_mode) |=> active);

endmodule

// File: rtl/pfg_mask.sv
module pfg_mask #(
   parameter int NUM_CH  = 3,
   parameter bit SAFE_HI = 1'b0,
   parameter bit SAFE_LO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [NUM_CH-1:0] hi_in,
   input  logic [NUM_CH-1:0] lo_in,
   output logic [NUM_CH-1:0] hi_out,
   output logic [NUM_CH-1:0] lo_out
);

   localparam logic [NUM_CH-1:0] HI_SAFE_V = {NUM_CH{SAFE_HI}};
   localparam logic [NUM_CH-1:0] LO_SAFE_V = {NUM_CH{SAFE_LO}};

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign hi_out[ch] = active ? SAFE_HI : hi_in[ch];
      assign lo_out[ch] = active ? SAFE_LO : lo_in[ch];
   end

   a_r4_safe : assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (hi_out == HI_SAFE_V && lo_out == LO_SAFE_V));

   a_r2_pass : assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (hi_out == hi_in && lo_out == lo_in));

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
   import pfg_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit CLR_SUSPEND = 1'b0,
   parameter bit SAFE_HI     = 1'b0,
   parameter bit SAFE_LO     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_in,
   input  logic              period_strobe,
   input  logic              cfg_latch_en,
   input  logic              clr_req,
   input  logic [NUM_CH-1:0] pwm_hi_in,
   input  logic [NUM_CH-1:0] pwm_lo_in,
   output logic [NUM_CH-1:0] pwm_hi_out,
   output logic [NUM_CH-1:0] pwm_lo_out,
   output logic              fault_active,
   output logic              fault_flag,
   output logic              clr_busy
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pwm_fault_guard: NUM_CH must be at least 1");
   end

   logic     fault_s;
   seq_ctl_t seq_ctl;

   pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (fault_in),
      .dout (fault_s)
   );

   pfg_clear_seq #(.CLR_SUSPEND(CLR_SUSPEND)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_req      (clr_req),
      .period_strobe(period_strobe),
      .ctl          (seq_ctl)
   );

   pfg_fault_store u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .fault_s (fault_s),
      .latch_en(cfg_latch_en),
      .ctl     (seq_ctl),
      .active  (fault_active),
      .flag    (fault_flag)
   );

   pfg_mask #(.NUM_CH(NUM_CH), .SAFE_HI(SAFE_HI), .SAFE_LO(SAFE_LO)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .active(fault_active),
      .hi_in (pwm_hi_in),
      .lo_in (pwm_lo_in),
      .hi_out(pwm_hi_out),
      .lo_out(pwm_lo_out)
   );

   assign clr_busy = seq_ctl.busy;

   // R5: a held fault survives one more clock unless a sequence may release it.
   a_r5_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (fault_active && cfg_latch_en && !clr_busy && !clr_req) |=> fault_active);

   a_r6_strobe_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag && !clr_busy) |=> fault_flag);

endmodule

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;

   localparam int N = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fault_in = 1'b0, period_strobe = 1'b0, cfg_latch_en = 1'b1, clr_req = 1'b0;
   logic [N-1:0] hi_in = '0, lo_in = '0;
   logic [N-1:0] hi0, lo0, hi1, lo1;
   logic act0, flag0, busy0, act1, flag1, busy1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm_fault_guard #(.NUM_CH(N), .CLR_SUSPEND(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .period_strobe(period_strobe),
      .cfg_latch_en(cfg_latch_en), .clr_req(clr_req), .pwm_hi_in(hi_in), .pwm_lo_in(lo_in),
      .pwm_hi_out(hi0), .pwm_lo_out(lo0), .fault_active(act0), .fault_flag(flag0),
      .clr_busy(busy0));

   pwm_fault_guard #(.NUM_CH(N), .CLR_SUSPEND(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .period_strobe(period_strobe),
      .cfg_latch_en(cfg_latch_en), .clr_req(clr_req), .pwm_hi_in(hi_in), .pwm_lo_in(lo_in),
      .pwm_hi_out(hi1), .pwm_lo_out(lo1), .fault_active(act1), .fault_flag(flag1),
      .clr_busy(busy1));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Expected drive outputs: safe level 0 when masked, else the inputs.
   task automatic chk_out(input string req, input bit m0, input bit m1);
      int e;
      e = {hi_in, lo_in};
      chk(req, "u0 drive", int'({hi0, lo0}), m0 ? 0 : e);
      chk(req, "u1 drive", int'({hi1, lo1}), m1 ? 0 : e);
   endtask

   task automatic chk_state(input string req, input bit a0, input bit f0, input bit b0,
                            input bit a1, input bit f1, input bit b1);
      chk(req, "u0 active", int'(act0), int'(a0));
      chk(req, "u0 flag",   int'(flag0), int'(f0));
      chk(req, "u0 busy",   int'(busy0), int'(b0));
      chk(req, "u1 active", int'(act1), int'(a1));
      chk(req, "u1 flag",   int'(flag1), int'(f1));
      chk(req, "u1 busy",   int'(busy1), int'(b1));
   endtask

   task automatic sweep(input string req, input bit m0, input bit m1);
      for (int p = 0; p < (1 << (2 * N)); p++) begin
         {hi_in, lo_in} = p[2*N-1:0];
         #1;
         chk_out(req, m0, m1);
      end
   endtask

   task automatic pulse_req(input bit with_strobe);
      clr_req = 1'b1;
      period_strobe = with_strobe;
      step(1);
      clr_req = 1'b0;
      period_strobe = 1'b0;
   endtask

   task automatic pulse_strobe;
      period_strobe = 1'b1;
      step(1);
      period_strobe = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      hi_in = 3'b101; lo_in = 3'b010; #1;
      chk_out("R1", 1'b0, 1'b0);
      chk_state("R1", 0, 0, 0, 0, 0, 0);

      // R2 pass-through for every pattern
      sweep("R2", 1'b0, 1'b0);

      // R3 synchronizer latency
      {hi_in, lo_in} = 6'h2D;
      fault_in = 1'b1;
      step(1);
      chk_out("R3", 1'b0, 1'b0);
      chk_state("R3", 0, 0, 0, 0, 0, 0);
      step(1);
      chk_out("R3", 1'b1, 1'b1);
      chk_state("R3", 1, 0, 0, 1, 0, 0);
      step(1);
      chk_state("R6", 1, 1, 0, 1, 1, 0);
      fault_in = 1'b0;
      step(4);
      // R5 latched after comparator drops; R4 masking of every pattern
      chk_state("R5", 1, 1, 0, 1, 1, 0);
      sweep("R4", 1'b1, 1'b1);

      // R6 strobe with no sequence has no effect
      pulse_strobe();
      step(1);
      chk_state("R6", 1, 1, 0, 1, 1, 0);

      // R7 phase one
      pulse_req(1'b0);
      chk_state("R7", 0, 1, 1, 1, 1, 1);
      step(1);
      chk_state("R7", 0, 1, 1, 0, 1, 1);
      chk_out("R7", 1'b0, 1'b0);

      // R9 request while busy is ignored
      pulse_req(1'b0);
      chk_state("R9", 0, 1, 1, 0, 1, 1);
      step(2);
      chk_state("R9", 0, 1, 1, 0, 1, 1);

      // R8 phase two at the strobe
      pulse_strobe();
      chk_state("R8", 0, 0, 0, 0, 0, 0);

      // R8 strobe in the request clock does not count
      fault_in = 1'b1; step(3); fault_in = 1'b0; step(3);
      chk_state("R5", 1, 1, 0, 1, 1, 0);
      pulse_req(1'b1);
      chk_state("R8", 0, 1, 1, 1, 1, 1);
      step(1);
      pulse_strobe();
      chk_state("R8", 0, 0, 0, 0, 0, 0);

      // R10 fault still present through the sequence
      fault_in = 1'b1; step(3);
      chk_state("R10", 1, 1, 0, 1, 1, 0);
      pulse_req(1'b0);
      chk_state("R10", 1, 1, 1, 1, 1, 1);
      step(1);
      pulse_strobe();
      chk_state("R10", 1, 1, 0, 1, 1, 0);
      fault_in = 1'b0;
      step(3);
      chk_state("R10", 1, 1, 0, 1, 1, 0);
      chk_out("R10", 1'b1, 1'b1);
      // clean release once the comparator is quiet
      pulse_req(1'b0);
      step(1);
      pulse_strobe();
      chk_state("R8", 0, 0, 0, 0, 0, 0);

      // R11 cycle-by-cycle operation
      cfg_latch_en = 1'b0;
      fault_in = 1'b1; step(2);
      chk_state("R11", 1, 0, 0, 1, 0, 0);
      fault_in = 1'b0; step(2);
      chk_state("R11", 0, 1, 0, 0, 1, 0);
      chk_out("R11", 1'b0, 1'b0);
      pulse_req(1'b0);
      chk_state("R11", 0, 1, 1, 0, 1, 1);
      pulse_strobe();
      chk_state("R11", 0, 0, 0, 0, 0, 0);
      cfg_latch_en = 1'b1;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule